// File: doc/BRIEF.md
# Pending and In-Service Interrupt Vector Tracker

This block holds two sets of interrupt vectors, each one bit per vector over the range 0 to 255. The pending set collects requested vectors that have not yet been taken. The in-service set holds vectors whose handlers are running. A request strobe adds a vector to the pending set. An acknowledge strobe moves the highest pending vector into the in-service set in one cycle. An end-of-interrupt strobe retires the highest in-service vector.

Each set is stored as a row of equal words. Each set has its own highest-vector encoder. The encoder takes the uppermost non-empty word and the most significant set bit inside that word. A registered copy of each highest vector goes to the outputs, and it is zero when the set is empty. A test port reads any single bit of either set combinationally, so that software-side logic or a neighbouring block can ask whether a given vector is pending or in service. Priority comparison against a task threshold, bus register access and level-trigger handshakes belong to other blocks.

Top module: `pst_tracker`

## Requirements
- R1: After reset both sets are empty, `pend_top` and `svc_top` read 0, and both test outputs read 0 for every vector.
- R2: A request with `req_vld` high adds `req_vec` to the pending set, stored in word `req_vec[7:5]` at bit `req_vec[4:0]`. From the next cycle on, `test_pend` reads 1 for that vector and stays 0 for the other vectors that were not requested.
- R3: `pend_top` is a register that holds the highest-numbered pending vector. It takes its new value in the cycle after the operation that changed the pending set, and it is 0 when the pending set is empty.
- R4: A request for a vector that is already pending leaves both sets and both outputs unchanged.
- R5: An acknowledge (`ack_vld`) clears the highest pending vector from the pending set and sets it in the in-service set, both at one clock edge. An acknowledge while the pending set is empty changes neither set.
- R6: An end-of-interrupt (`eoi_vld`) clears the highest in-service vector. An end-of-interrupt while the in-service set is empty changes nothing.
- R7: `svc_top` is a register that holds the highest-numbered in-service vector. It is updated in the cycle after the change, and it is 0 when the set is empty.
- R8: A request and an acknowledge in the same cycle: the acknowledge takes the highest vector that was pending before the request. If the request names that same vector, the vector leaves the pending set.
- R9: An acknowledge and an end-of-interrupt in the same cycle: the end-of-interrupt retires the in-service vector that was highest before the cycle, and the acknowledged vector enters the in-service set.
- R10: `test_pend` and `test_svc` show, without a clock delay, the bit for `test_vec` in the pending and in-service sets as they are in the current cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Request strobe |
| req_vec | input | 8 | Vector to add to the pending set |
| ack_vld | input | 1 | Acknowledge strobe: move highest pending vector into service |
| eoi_vld | input | 1 | End-of-interrupt strobe: retire highest in-service vector |
| test_vec | input | 8 | Vector probed by the test outputs |
| test_pend | output | 1 | Pending bit of `test_vec` |
| test_svc | output | 1 | In-service bit of `test_vec` |
| pend_top | output | 8 | Registered highest pending vector, 0 when empty |
| svc_top | output | 8 | Registered highest in-service vector, 0 when empty |

## Verification
The assertions assume that the strobes are sampled only at rising edges and are known whenever reset is released. They also assume that reset is held across at least one edge before the first operation, because the reset property looks one cycle back. They do not assume that the strobes are mutually exclusive. The stimulus drives every input at the falling edge. It combines the three strobes freely, including on empty sets. A scoreboard model settles simultaneous strobes with the same rules as R8 and R9, so that every combination stays inside checked behaviour.

// File: rtl/pst_pkg.sv
package pst_pkg;
   // Variant of the highest-vector encoder.
   typedef enum logic [0:0] {
      ENC_WORDWISE = 1'b0,   // per-word MSB, then top non-empty word
      ENC_FLAT     = 1'b1    // one scan across the whole set
   } pst_enc_e;

   localparam int unsigned PST_WORDS_DEF  = 8;
   localparam int unsigned PST_WORD_W_DEF = 32;
endpackage

// File: rtl/pst_vec_set.sv
// One vector set stored as NUM_WORDS words of WORD_W bits.
// SET_WINS picks the outcome when set and clear hit the same bit.
module pst_vec_set #(
   parameter int unsigned NUM_WORDS = pst_pkg::PST_WORDS_DEF,
   parameter int unsigned WORD_W    = pst_pkg::PST_WORD_W_DEF,
   parameter bit          SET_WINS  = 1'b0,
   localparam int unsigned TOT   = NUM_WORDS * WORD_W,
   localparam int unsigned VEC_W = $clog2(TOT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_en,
   input  logic [VEC_W-1:0] set_vec,
   input  logic             clr_en,
   input  logic [VEC_W-1:0] clr_vec,
   output logic [TOT-1:0]   bits_q,
   output logic [TOT-1:0]   bits_nxt
);
   localparam int unsigned BIT_W = $clog2(WORD_W);
   localparam int unsigned IDX_W = VEC_W - BIT_W;

   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] set_m;
      logic [WORD_W-1:0] clr_m;
      logic [WORD_W-1:0] word_nxt;

      assign set_m = (set_en && (set_vec[VEC_W-1:BIT_W] == IDX_W'(w)))
                     ? (WORD_W'(1) << set_vec[BIT_W-1:0]) : '0;
      assign clr_m = (clr_en && (clr_vec[VEC_W-1:BIT_W] == IDX_W'(w)))
                     ? (WORD_W'(1) << clr_vec[BIT_W-1:0]) : '0;

      if (SET_WINS) begin : g_set_wins
         assign word_nxt = (word_q & ~clr_m) | set_m;
      end else begin : g_clr_wins
         assign word_nxt = (word_q | set_m) & ~clr_m;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) word_q <= '0;
         else        word_q <= word_nxt;
      end

      assign bits_q[w*WORD_W +: WORD_W]   = word_q;
      assign bits_nxt[w*WORD_W +: WORD_W] = word_nxt;
   end
endmodule

// File: rtl/pst_msb_enc.sv
// Highest set bit of a word-organised set; vec is 0 when empty.
module pst_msb_enc #(
   parameter int unsigned     NUM_WORDS = pst_pkg::PST_WORDS_DEF,
   parameter int unsigned     WORD_W    = pst_pkg::PST_WORD_W_DEF,
   parameter pst_pkg::pst_enc_e STYLE   = pst_pkg::ENC_WORDWISE,
   localparam int unsigned TOT   = NUM_WORDS * WORD_W,
   localparam int unsigned VEC_W = $clog2(TOT)
) (
   input  logic [TOT-1:0]   bits,
   output logic             any,
   output logic [VEC_W-1:0] vec
);
   localparam int unsigned BIT_W = $clog2(WORD_W);
   localparam int unsigned IDX_W = VEC_W - BIT_W;

   if (STYLE == pst_pkg::ENC_WORDWISE) begin : g_wordwise
      logic [NUM_WORDS-1:0] nz;
      logic [BIT_W-1:0]     pos [NUM_WORDS];

      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_w
         logic [WORD_W-1:0] word;
         assign word  = bits[w*WORD_W +: WORD_W];
         assign nz[w] = |word;
         always_comb begin
            pos[w] = '0;
            for (int b = 0; b < WORD_W; b++)
               if (word[b]) pos[w] = BIT_W'(b);
         end
      end

      // Top word wins: later iterations overwrite lower words.
      always_comb begin
         vec = '0;
         for (int w = 0; w < NUM_WORDS; w++)
            if (nz[w]) vec = {IDX_W'(w), pos[w]};
      end
      assign any = |nz;
   end else begin : g_flat
      always_comb begin
         vec = '0;
         for (int i = 0; i < TOT; i++)
            if (bits[i]) vec = VEC_W'(i);
      end
      assign any = |bits;
   end
endmodule

// File: rtl/pst_tracker.sv
module pst_tracker #(
   parameter int unsigned       NUM_WORDS = pst_pkg::PST_WORDS_DEF,
   parameter int unsigned       WORD_W    = pst_pkg::PST_WORD_W_DEF,
   parameter pst_pkg::pst_enc_e ENC_STYLE = pst_pkg::ENC_WORDWISE,
   localparam int unsigned VEC_W = $clog2(NUM_WORDS * WORD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_vld,
   input  logic [VEC_W-1:0] req_vec,
   input  logic             ack_vld,
   input  logic             eoi_vld,
   input  logic [VEC_W-1:0] test_vec,
   output logic             test_pend,
   output logic             test_svc,
   output logic [VEC_W-1:0] pend_top,
   output logic [VEC_W-1:0] svc_top
);
   localparam int unsigned TOT = NUM_WORDS * WORD_W;

   // Elaboration checks on the shape of the sets.
   if (NUM_WORDS < 2 || (NUM_WORDS & (NUM_WORDS - 1)) != 0) begin : g_bad_words
      $error("pst_tracker: NUM_WORDS must be a power of two >= 2");
   end
   if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_width
      $error("pst_tracker: WORD_W must be a power of two >= 2");
   end

   logic [TOT-1:0]   pend_q, pend_nxt, svc_q, svc_nxt;
   logic             pend_any_nxt, svc_any_nxt;
   logic [VEC_W-1:0] pend_top_nxt, svc_top_nxt;
   logic             pend_any_q, svc_any_q;
   logic [VEC_W-1:0] pend_top_q, svc_top_q;
   logic             ack_eff, eoi_eff;

   // Strobes only act on a non-empty set; they use the registered tops,
   // which always describe the sets as they stand this cycle (R5, R6).
   assign ack_eff = ack_vld & pend_any_q;
   assign eoi_eff = eoi_vld & svc_any_q;

   // Pending: clear (acknowledge) beats set (request) on one bit (R8).
   pst_vec_set #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SET_WINS(1'b0)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (req_vld),
      .set_vec  (req_vec),
      .clr_en   (ack_eff),
      .clr_vec  (pend_top_q),
      .bits_q   (pend_q),
      .bits_nxt (pend_nxt)
   );

   // In service: set (acknowledge) beats clear (end-of-interrupt) (R9).
   pst_vec_set #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .SET_WINS(1'b1)) u_svc (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (ack_eff),
      .set_vec  (pend_top_q),
      .clr_en   (eoi_eff),
      .clr_vec  (svc_top_q),
      .bits_q   (svc_q),
      .bits_nxt (svc_nxt)
   );

   pst_msb_enc #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .STYLE(ENC_STYLE)) u_pend_enc (
      .bits (pend_nxt),
      .any  (pend_any_nxt),
      .vec  (pend_top_nxt)
   );

   pst_msb_enc #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .STYLE(ENC_STYLE)) u_svc_enc (
      .bits (svc_nxt),
      .any  (svc_any_nxt),
      .vec  (svc_top_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_any_q <= 1'b0;
         pend_top_q <= '0;
         svc_any_q  <= 1'b0;
         svc_top_q  <= '0;
      end else begin
         pend_any_q <= pend_any_nxt;
         pend_top_q <= pend_top_nxt;
         svc_any_q  <= svc_any_nxt;
         svc_top_q  <= svc_top_nxt;
      end
   end

   assign pend_top  = pend_top_q;
   assign svc_top   = svc_top_q;
   assign test_pend = pend_q[test_vec];
   assign test_svc  = svc_q[test_vec];
endmodule

// File: rtl/pst_tracker_chk.sv
module pst_tracker_chk #(
   parameter int unsigned VEC_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_vld,
   input logic [VEC_W-1:0] req_vec,
   input logic             ack_vld,
   input logic             eoi_vld,
   input logic             pend_any,
   input logic             svc_any,
   input logic [VEC_W-1:0] pend_top,
   input logic [VEC_W-1:0] svc_top
);
   // R1: first cycle out of reset shows empty tops.
   p_reset_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (pend_top == '0 && svc_top == '0 && !pend_any && !svc_any));

   // R2: a request leaves the pending set non-empty with a top at least that vector.
   p_req_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld && !ack_vld) |=> (pend_any && pend_top >= $past(req_vec)));

   // R3 / R7: with no strobe, neither top moves.
   p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_vld && !ack_vld && !eoi_vld) |=> ($stable(pend_top) && $stable(svc_top)));

   // R5: acknowledge on empty pending set leaves the service side untouched.
   p_ack_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && !pend_any && !req_vld && !eoi_vld) |=> (!pend_any && $stable(svc_top)));

   // R5: acknowledge moves the pending top into service.
   p_ack_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_vld && pend_any && !eoi_vld) |=> (svc_any && svc_top >= $past(pend_top)));

   // R6: end-of-interrupt on an empty service set keeps it empty.
   p_eoi_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_vld && !svc_any && !(ack_vld && pend_any)) |=> !svc_any);
endmodule

bind pst_tracker pst_tracker_chk #(.VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_vld  (req_vld),
   .req_vec  (req_vec),
   .ack_vld  (ack_vld),
   .eoi_vld  (eoi_vld),
   .pend_any (pend_any_q),
   .svc_any  (svc_any_q),
   .pend_top (pend_top_q),
   .svc_top  (svc_top_q)
);

// File: tb/pst_tracker_tb_top.sv
module pst_tracker_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_vld = 1'b0, ack_vld = 1'b0, eoi_vld = 1'b0;
   logic [7:0] req_vec = '0, test_vec = '0;
   logic       test_pend, test_svc;
   logic [7:0] pend_top, svc_top;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   typedef struct {
      logic [7:0] pend;
      logic [7:0] svc;
      string      tag;
   } exp_t;
   exp_t exp_q[$];

   logic [255:0] pm = '0;   // model of the pending set
   logic [255:0] sm = '0;   // model of the in-service set

   always #5 clk = ~clk;    // 100 MHz

   pst_tracker dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_vec(req_vec),
      .ack_vld(ack_vld), .eoi_vld(eoi_vld), .test_vec(test_vec),
      .test_pend(test_pend), .test_svc(test_svc),
      .pend_top(pend_top), .svc_top(svc_top)
   );

   function automatic logic [7:0] hi(input logic [255:0] s);
      logic [7:0] r = '0;
      for (int i = 0; i < 256; i++) if (s[i]) r = 8'(i);
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Driver: one operation per cycle, expected tops pushed to the scoreboard.
   task automatic do_op(input bit rq, input logic [7:0] rv, input bit ak,
                        input bit eo, input string tag);
      logic [255:0] npm, nsm;
      logic [7:0]   av, ev;
      bit           ak_e, eo_e;
      exp_t         e;
      ak_e = ak && (pm != '0);
      eo_e = eo && (sm != '0);
      av = hi(pm);
      ev = hi(sm);
      npm = pm;
      nsm = sm;
      if (rq)   npm[rv] = 1'b1;
      if (ak_e) npm[av] = 1'b0;
      if (eo_e) nsm[ev] = 1'b0;
      if (ak_e) nsm[av] = 1'b1;
      pm = npm;
      sm = nsm;
      e.pend = hi(pm);
      e.svc  = hi(sm);
      e.tag  = tag;
      exp_q.push_back(e);
      req_vld = rq; req_vec = rv; ack_vld = ak; eoi_vld = eo;
      @(negedge clk);
      req_vld = 1'b0; ack_vld = 1'b0; eoi_vld = 1'b0;
   endtask

   // Combinational probe of both sets (R10), at a falling edge.
   task automatic probe(input logic [7:0] v, input string tag);
      test_vec = v;
      #1;
      check(test_pend === pm[v], tag, int'(test_pend), int'(pm[v]));
      check(test_svc  === sm[v], tag, int'(test_svc),  int'(sm[v]));
   endtask

   // Monitor: compares registered tops after the edge that follows each op.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check(pend_top === e.pend, {e.tag, " pend_top"}, int'(pend_top), int'(e.pend));
            check(svc_top  === e.svc,  {e.tag, " svc_top"},  int'(svc_top),  int'(e.svc));
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(pend_top === 8'd0, "R1 pend_top", int'(pend_top), 0);
      check(svc_top  === 8'd0, "R1 svc_top",  int'(svc_top),  0);
      probe(8'd0,   "R1");
      probe(8'd255, "R1");

      do_op(1'b0, 8'd0, 1'b1, 1'b0, "R5 ack on empty");
      do_op(1'b0, 8'd0, 1'b0, 1'b1, "R6 eoi on empty");
      probe(8'd0, "R5");
      // R2: vector 0 is distinguishable from empty only through the probe
      do_op(1'b1, 8'd0, 1'b0, 1'b0, "R2 req 0");
      probe(8'd0, "R2");
      do_op(1'b1, 8'd37,  1'b0, 1'b0, "R3 req 37");
      do_op(1'b1, 8'd200, 1'b0, 1'b0, "R3 req 200");
      do_op(1'b1, 8'd255, 1'b0, 1'b0, "R3 req 255");
      probe(8'd37, "R2 word1 bit5");
      probe(8'd36, "R2 neighbour");
      do_op(1'b1, 8'd37, 1'b0, 1'b0, "R4 repeat req");
      probe(8'd37, "R4");
      do_op(1'b0, 8'd0, 1'b1, 1'b0, "R5 ack 255");
      probe(8'd255, "R5 moved");
      do_op(1'b1, 8'd201, 1'b1, 1'b0, "R8 req+ack");
      probe(8'd200, "R8");
      probe(8'd201, "R8");
      do_op(1'b1, 8'd201, 1'b1, 1'b0, "R8 same vector");
      probe(8'd201, "R8 same");
      do_op(1'b0, 8'd0, 1'b1, 1'b1, "R9 ack+eoi");
      probe(8'd255, "R9");
      do_op(1'b0, 8'd0, 1'b0, 1'b1, "R7 eoi");
      do_op(1'b0, 8'd0, 1'b0, 1'b1, "R7 eoi");
      do_op(1'b0, 8'd0, 1'b0, 1'b1, "R7 eoi drain");
      do_op(1'b0, 8'd0, 1'b0, 1'b1, "R6 eoi drained");

      for (int k = 0; k < 600; k++) begin
         logic [7:0] v;
         int         sel;
         v   = 8'($urandom_range(0, 255));
         sel = $urandom_range(0, 9);
         do_op(sel < 5, v, (sel >= 3 && sel < 7), (sel >= 6), "R3 R7 mixed");
         if (k % 8 == 0) probe(v, "R10");
      end
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule